// File: doc/BRIEF.md
# Bit-Serial CRC Accelerator for a Processor Datapath

This unit sits beside a processor's arithmetic unit and works as a multicycle instruction. It computes a cyclic redundancy check over one 32-bit word. A one-cycle start pulse captures the message word from operand A, the running checksum from operand B and a width code. The unit then feeds the word into a Galois-form shift register one bit per clock, most significant bit first. When all 32 bits have gone in, it raises a one-cycle completion pulse and presents the new checksum, zero-extended to 32 bits.

Software checksums a buffer by issuing one instruction per word. The result of each word is passed back as operand B of the next word. Three generators are available at run time: x^8+x^2+x+1 (0x07), x^16+x^15+x^2+1 (0x8005) and the 32-bit Ethernet-style generator 0x04C11DB7. No input or output reflection and no final inversion is applied. Any preset or final XOR is left to the caller.

Top module: `crc_ci_unit`

## Requirements
- R1: While `rst` is high at a rising edge and on the cycle after, `done` is 0 and `result` is 0.
- R2: With `width_sel` = 2'b10 the result is the 32-bit CRC, generator 0x04C11DB7. The register starts at operand B. Operand A is shifted in MSB first, with feedback = register bit 31 XOR data bit. There is no reflection and no final XOR, so the result of one word can seed the next.
- R3: With `width_sel` = 2'b01 the result is the 16-bit CRC, generator 0x8005, with feedback taken from register bit 15.
- R4: With `width_sel` = 2'b00 the result is the 8-bit CRC, generator 0x07, with feedback from bit 7. The code 2'b11 behaves exactly like 2'b10.
- R5: If `start` is sampled at rising edge E while the unit is idle, `done` is high for exactly the one cycle after edge E+32, and low otherwise.
- R6: A `start` sampled while an operation is in progress has no effect. Changes to `op_a`, `op_b` and `width_sel` during an operation also have no effect on its result.
- R7: For the 8-bit and 16-bit widths, the bits of operand B above the width are ignored, and the result bits above the width are 0.
- R8: `result` holds its value until the next completion. A `start` sampled in the cycle where `done` is high is accepted.
- R9: A reset during an operation aborts it: no `done` follows until a new `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation |
| width_sel | input | 2 | Generator select: 00 8-bit, 01 16-bit, 10/11 32-bit |
| op_a | input | 32 | Message word, shifted in MSB first |
| op_b | input | 32 | Previous checksum (seed) |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Checksum, zero-extended, held between completions |

## Verification
The bench targets these corner cases:
- A start issued mid-operation with different operands. A design that re-loaded would complete early or return the checksum of the wrong word.
- Width-select changes while busy. A design that did not latch the width would tap the wrong feedback bit.
- Seeds with garbage above the 8-bit and 16-bit widths. These expose missing masks as nonzero upper result bits.
- Back-to-back instructions started in the done cycle, and checksums chained through operand B. These catch an off-by-one in the 32-cycle count or a lost acceptance.
- A reset mid-operation, which must not leave a stray completion pulse behind.

// File: rtl/crc_ci_pkg.sv
package crc_ci_pkg;

  typedef enum logic [1:0] {
    WSEL_8   = 2'b00,
    WSEL_16  = 2'b01,
    WSEL_32  = 2'b10,
    WSEL_32B = 2'b11
  } wsel_e;

  localparam int REG_W = 32;

  localparam logic [REG_W-1:0] GEN_8  = 32'h0000_0007;
  localparam logic [REG_W-1:0] GEN_16 = 32'h0000_8005;
  localparam logic [REG_W-1:0] GEN_32 = 32'h04C1_1DB7;

  function automatic logic [REG_W-1:0] width_mask(input wsel_e s);
    case (s)
      WSEL_8:  width_mask = 32'h0000_00FF;
      WSEL_16: width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] gen_poly(input wsel_e s);
    case (s)
      WSEL_8:  gen_poly = GEN_8;
      WSEL_16: gen_poly = GEN_16;
      default: gen_poly = GEN_32;
    endcase
  endfunction

endpackage

// File: rtl/crc_ci_ctrl.sv
module crc_ci_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic shift,
  output logic last,
  output logic done
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;

  assign load  = start && !busy;
  assign shift = busy;
  assign last  = busy && (cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (load) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5
  AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy)); // R5
  AST_COUNT_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != LAST_CNT) |=> (busy && cnt == $past(cnt) + 1'b1)); // R6
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    last |=> !busy); // R5

endmodule

// File: rtl/crc_ci_shifter.sv
module crc_ci_shifter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] word_in,
  output logic              bit_out
);
  logic [DATA_W-1:0] word_q;

  assign bit_out = word_q[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst)        word_q <= '0;
    else if (load)  word_q <= word_in;
    else if (shift) word_q <= {word_q[DATA_W-2:0], 1'b0};
  end

endmodule

// File: rtl/crc_ci_lfsr.sv
module crc_ci_lfsr
  import crc_ci_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  wsel_e            sel_in,
  input  logic [REG_W-1:0] seed,
  input  logic             din,
  output wsel_e            sel_q,
  output logic [REG_W-1:0] state_next
);
  logic [REG_W-1:0] state_q;
  logic [REG_W-1:0] poly;
  logic [REG_W-1:0] mask;
  logic [REG_W-1:0] raw_next;
  logic             fb;

  assign poly = gen_poly(sel_q);
  assign mask = width_mask(sel_q);

  always_comb begin
    case (sel_q)
      WSEL_8:  fb = state_q[7]  ^ din;
      WSEL_16: fb = state_q[15] ^ din;
      default: fb = state_q[31] ^ din;
    endcase
  end

  genvar i;
  generate
    for (i = 0; i < REG_W; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign raw_next[i] = fb;
      end else begin : g_rest
        assign raw_next[i] = state_q[i-1] ^ (fb & poly[i]);
      end
    end
  endgenerate

  assign state_next = raw_next & mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      sel_q   <= WSEL_32;
    end else if (load) begin
      state_q <= seed & width_mask(sel_in);
      sel_q   <= sel_in;
    end else if (shift) begin
      state_q <= state_next;
    end
  end

  AST_STATE_IN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (state_q & ~mask) == '0); // R7

endmodule

// File: rtl/crc_ci_unit.sv
module crc_ci_unit
  import crc_ci_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        width_sel,
  input  logic [DATA_W-1:0] op_a,
  input  logic [REG_W-1:0]  op_b,
  output logic              done,
  output logic [REG_W-1:0]  result
);
  logic             load, shift, last, data_bit;
  wsel_e            sel_q;
  logic [REG_W-1:0] state_next;

  crc_ci_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .load(load), .shift(shift), .last(last), .done(done)
  );

  crc_ci_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .shift(shift),
    .word_in(op_a), .bit_out(data_bit)
  );

  crc_ci_lfsr u_lfsr (
    .clk(clk), .rst(rst), .load(load), .shift(shift),
    .sel_in(wsel_e'(width_sel)), .seed(op_b), .din(data_bit),
    .sel_q(sel_q), .state_next(state_next)
  );

  always_ff @(posedge clk) begin
    if (rst)       result <= '0;
    else if (last) result <= state_next;
  end

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> $stable(result)); // R8
  AST_ZERO_EXT_8: assert property (@(posedge clk) disable iff (rst)
    (done && sel_q == WSEL_8) |-> (result[REG_W-1:8] == '0)); // R7
  AST_ZERO_EXT_16: assert property (@(posedge clk) disable iff (rst)
    (done && sel_q == WSEL_16) |-> (result[REG_W-1:16] == '0)); // R7

endmodule

// File: tb/crc_ci_unit_test.sv
module crc_ci_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  width_sel = 2'b10;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        done;
  logic [31:0] result;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // reference model state
  int          m_busy = 0;
  int          m_cnt = 0;
  bit          m_aborted = 0;
  logic [31:0] m_a, m_b;
  logic [1:0]  m_s;
  logic        exp_done = 1'b0;
  logic [31:0] exp_res = '0;
  int          done_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_ci_unit uut (
    .clk(clk), .rst(rst), .start(start), .width_sel(width_sel),
    .op_a(op_a), .op_b(op_b), .done(done), .result(result)
  );

  function automatic logic [31:0] ref_crc(input logic [31:0] d,
                                          input logic [31:0] seed,
                                          input logic [1:0] s);
    int w;
    logic [31:0] p, m, c;
    logic fb;
    w = (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 32;
    p = (w == 8) ? 32'h07 : (w == 16) ? 32'h8005 : 32'h04C11DB7;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
    c = seed & m;
    for (int i = 31; i >= 0; i--) begin
      fb = c[w-1] ^ d[i];
      c = (c << 1) & m;
      if (fb) c = c ^ p;
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // reference model: inputs are driven at negedge, so they are stable here
  always @(posedge clk) begin
    cycles++;
    exp_done = 1'b0;
    if (rst) begin
      m_busy = 0;
      m_cnt = 0;
      exp_res = '0;
    end else begin
      if (m_busy != 0) begin
        m_cnt++;
        if (m_cnt == 32) begin
          m_busy = 0;
          exp_done = 1'b1;
          exp_res = ref_crc(m_a, m_b, m_s);
        end
      end else if (start) begin
        m_busy = 1;
        m_cnt = 0;
        m_a = op_a;
        m_b = op_b;
        m_s = width_sel;
      end
    end
  end

  // compare every cycle: R1 reset, R5 timing, R2/R3/R4/R7/R8 result
  always @(negedge clk) begin
    check(done === exp_done, "R5/R1 done", {31'b0, done}, {31'b0, exp_done});
    check(result === exp_res, "R2/R8 result", result, exp_res);
    if (done) done_seen++;
  end

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [1:0] s);
    @(negedge clk);
    op_a = a; op_b = b; width_sel = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (done !== 1'b1) @(negedge clk);
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [1:0] s,
                     input string req);
    issue(a, b, s);
    wait_done();
    check(result === ref_crc(a, b, s), req, result, ref_crc(a, b, s));
  endtask

  initial begin : watchdog
    while (cycles < WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] chain;
    repeat (3) @(negedge clk);
    check(done === 1'b0 && result === 32'h0, "R1 reset state", result, 32'h0);
    rst = 1'b0;

    run(32'h1234_5678, 32'h0000_0000, 2'b10, "R2 crc32 basic");
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b10, "R2 crc32 ones");
    run(32'h8000_0001, 32'hDEAD_BEEF, 2'b01, "R3 crc16");
    run(32'hA5A5_0F0F, 32'hFFFF_1234, 2'b01, "R7 crc16 seed upper ignored");
    check(result[31:16] === 16'h0, "R7 crc16 upper zero", result, 32'h0);
    run(32'h0000_00C3, 32'hFFFF_FF5A, 2'b00, "R4 crc8 / R7 seed mask");
    check(result[31:8] === 24'h0, "R7 crc8 upper zero", result, 32'h0);
    run(32'hCAFE_F00D, 32'h0BAD_CAFE, 2'b11, "R4 code 11 as crc32");

    // chained words, R2
    chain = 32'hFFFF_FFFF;
    for (int k = 0; k < 4; k++) begin
      run(32'h0101_0101 * (k + 3), chain, 2'b10, "R2 chained word");
      chain = result;
    end

    // R6: start and operand changes while busy ignored
    issue(32'h1357_9BDF, 32'h2468_ACE0, 2'b01);
    repeat (5) @(negedge clk);
    op_a = 32'hFFFF_0000; op_b = 32'h0; width_sel = 2'b00; start = 1'b1;
    @(negedge clk);
    start = 1'b0; width_sel = 2'b10;
    wait_done();
    check(result === ref_crc(32'h1357_9BDF, 32'h2468_ACE0, 2'b01), "R6 busy start ignored",
          result, ref_crc(32'h1357_9BDF, 32'h2468_ACE0, 2'b01));
    @(negedge clk);
    check(done === 1'b0, "R6 no second done", {31'b0, done}, 32'h0);
    repeat (40) @(negedge clk);
    check(result === ref_crc(32'h1357_9BDF, 32'h2468_ACE0, 2'b01), "R8 result held",
          result, ref_crc(32'h1357_9BDF, 32'h2468_ACE0, 2'b01));

    // R8: start in done cycle accepted
    issue(32'h0F0F_0F0F, 32'h0, 2'b10);
    wait_done();
    op_a = 32'h7777_0000; op_b = 32'h1111_2222; width_sel = 2'b01; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check(result === ref_crc(32'h7777_0000, 32'h1111_2222, 2'b01), "R8 back-to-back",
          result, ref_crc(32'h7777_0000, 32'h1111_2222, 2'b01));

    // R9: reset mid-operation aborts
    issue(32'h5555_AAAA, 32'h1, 2'b10);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    done_seen = 0;
    repeat (50) @(negedge clk);
    check(done_seen == 0, "R9 no done after abort", done_seen, 0);
    check(result === 32'h0, "R9/R1 result cleared", result, 32'h0);
    run(32'h0000_0000, 32'h0000_0000, 2'b00, "R4 crc8 zero");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule